// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits between two interrupt request lines and a CPU core and decides when and how the core enters an interrupt. One line is a maskable external channel and the other is a non-maskable top-level request. Each line passes through a synchronizer and a rising-edge detector that sets a sticky pending bit. Pending bits are only looked at on a fixed sampling grid, produced by a free-running counter. When a sample finds work, an arbitration phase runs for a fixed number of cycles without regard to instruction flow. The non-maskable request gets a shortened arbitration phase.

When arbitration ends, the sequencer decides what happens to the running instruction. If that instruction has not yet written anything, it is aborted on the spot. If it has written, the sequencer holds until the core reports that the instruction has finished. If the core is idling in wait-for-interrupt mode, there is no instruction to abort, and a single wake-up cycle is inserted instead.

After a one-cycle acknowledge, the block drives the interrupt machine cycle. The machine cycle is a run of stack-push cycles followed by vector handling, and it ends with a one-cycle vector-fetch strobe. Its length grows when the stack sits in the register file and again when the code segment register is saved. Priority among more than two sources and the stacking datapath belong to neighbouring blocks.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request edges, abort_o, ack_o, push_o and vec_fetch_o are all low.
- R2: Pending bits are sampled only on clock edges whose count since reset release is a multiple of 5. A request line that rises before clock edge a is taken at the first such edge k with k >= a+3; it waits there if it arrives later.
- R3: Only a rising edge of a request line creates a pending request. A line held high after being serviced, and its falling edge, cause no further acknowledge.
- R4: Arbitration lasts 5 cycles for the external line and 1 cycle for the non-maskable line (4 cycles faster). When both are pending at a sample, the non-maskable line is served first.
- R5: If wr_done_i is low at the edge ending arbitration (and the core is not waiting), ack_o and abort_o are both high in the cycle after that edge.
- R6: If wr_done_i is high at the edge ending arbitration (and the core is not waiting), abort_o stays low and ack_o rises in the cycle after the first edge at which instr_done_i is high.
- R7: ack_o is high for exactly one cycle per serviced request.
- R8: The machine cycle lasts 18 cycles, plus 2 when stk_in_rf_i is high, plus 2 more when push_seg_i is high. push_o is high for its first (length-2) cycles, and vec_fetch_o is high for its final cycle only.
- R9: If wait_mode_i is high at the edge ending arbitration, ack_o follows at once without abort and without waiting for instr_done_i, and one idle wake-up cycle separates ack_o from the machine cycle.
- R10: A request that becomes pending while another is in service is held. It is sampled at the first grid edge that comes at least two edges after the vector-fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_req_i | input | 1 | Maskable external request line, edge-sensitive |
| nmi_req_i | input | 1 | Non-maskable top-level request line, edge-sensitive |
| wr_done_i | input | 1 | Current instruction has already performed a write |
| instr_done_i | input | 1 | Current instruction completes at this edge |
| wait_mode_i | input | 1 | Core idles in wait-for-interrupt mode |
| stk_in_rf_i | input | 1 | Stack lives in the register file (+2 machine cycles) |
| push_seg_i | input | 1 | Code segment register is pushed (+2 machine cycles) |
| abort_o | output | 1 | Abort the running instruction (with ack_o) |
| ack_o | output | 1 | Interrupt acknowledge, one cycle |
| push_o | output | 1 | Stack-push phase of the machine cycle |
| vec_fetch_o | output | 1 | Vector fetch strobe, last machine-cycle cycle |

## Verification
The bench counts clock edges from reset release, so for every request it knows the sampling edge k. The acknowledge is due after edge k+A, where A is 5 for the external line and 1 for the non-maskable one. When the instruction has written, the acknowledge is due instead one edge after instr_done_i is presented. The vector-fetch strobe is due after edge ack+w+L, where w is the wake-up cycle and L is the machine-cycle length. Every output is read at the falling edge and logged against the index of the preceding rising edge. Each acknowledge, abort, push-cycle count and vector-fetch index is then compared exactly with these predictions for every combination of source, write flag, stack location, segment push and wait mode.

// File: rtl/ies_pkg.sv
package ies_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARB,
      ST_HOLD,
      ST_ACK,
      ST_WAKE,
      ST_MC
   } ies_state_e;

   localparam int SRC_NMI = 0;
   localparam int SRC_EXT = 1;
   localparam int N_SRC   = 2;
endpackage

// File: rtl/ies_edge.sv
module ies_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   input  logic clr_i,
   output logic pend_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pend_q;
   logic                   rise;

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], req_i};
         prev_q <= sync_q[SYNC_STAGES-1];
         // a fresh edge wins over a clear in the same cycle
         pend_q <= (pend_q & ~clr_i) | rise;
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/ies_window.sv
module ies_window #(
   parameter int WIN_LEN = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   localparam int CW = $clog2(WIN_LEN);
   localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/ies_fsm.sv
module ies_fsm
   import ies_pkg::*;
#(
   parameter int ARB_CYC   = 5,
   parameter int NMI_SKIP  = 4,
   parameter int MC_BASE   = 18,
   parameter int RF_EXTRA  = 2,
   parameter int SEG_EXTRA = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [N_SRC-1:0] pend_i,
   input  logic             wr_done_i,
   input  logic             instr_done_i,
   input  logic             wait_mode_i,
   input  logic             stk_in_rf_i,
   input  logic             push_seg_i,
   output logic [N_SRC-1:0] clr_o,
   output logic             abort_o,
   output logic             ack_o,
   output logic             push_o,
   output logic             vec_fetch_o
);
   localparam int MC_MAX  = MC_BASE + RF_EXTRA + SEG_EXTRA;
   localparam int CNT_TOP = (MC_MAX > ARB_CYC) ? MC_MAX : ARB_CYC;
   localparam int CNT_W   = $clog2(CNT_TOP + 1);

   ies_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             nmi_sel_q;
   logic             abort_q;
   logic             wake_q;
   logic [CNT_W-1:0] arb_load;
   logic [CNT_W-1:0] mc_load;

   generate
      if (NMI_SKIP > 0) begin : g_fast_nmi
         assign arb_load = pend_i[SRC_NMI] ? CNT_W'(ARB_CYC - NMI_SKIP - 1)
                                           : CNT_W'(ARB_CYC - 1);
      end else begin : g_flat_arb
         assign arb_load = CNT_W'(ARB_CYC - 1);
      end
   endgenerate

   assign mc_load = CNT_W'(MC_BASE - 1)
                  + (stk_in_rf_i ? CNT_W'(RF_EXTRA)  : CNT_W'(0))
                  + (push_seg_i  ? CNT_W'(SEG_EXTRA) : CNT_W'(0));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         nmi_sel_q <= 1'b0;
         abort_q   <= 1'b0;
         wake_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (tick_i && (|pend_i)) begin
                  nmi_sel_q <= pend_i[SRC_NMI];
                  cnt_q     <= arb_load;
                  state_q   <= ST_ARB;
               end
            end
            ST_ARB: begin
               if (cnt_q == '0) begin
                  wake_q <= wait_mode_i;
                  if (wait_mode_i) begin
                     abort_q <= 1'b0;
                     state_q <= ST_ACK;
                  end else if (!wr_done_i) begin
                     abort_q <= 1'b1;
                     state_q <= ST_ACK;
                  end else begin
                     abort_q <= 1'b0;
                     state_q <= ST_HOLD;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_HOLD: begin
               if (instr_done_i) begin
                  state_q <= ST_ACK;
               end
            end
            ST_ACK: begin
               cnt_q   <= mc_load;
               state_q <= wake_q ? ST_WAKE : ST_MC;
            end
            ST_WAKE: begin
               state_q <= ST_MC;
            end
            ST_MC: begin
               if (cnt_q == '0) begin
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      clr_o = '0;
      if (state_q == ST_ACK) begin
         clr_o[SRC_NMI] = nmi_sel_q;
         clr_o[SRC_EXT] = ~nmi_sel_q;
      end
   end

   assign ack_o       = (state_q == ST_ACK);
   assign abort_o     = (state_q == ST_ACK) && abort_q;
   assign push_o      = (state_q == ST_MC) && (cnt_q >= CNT_W'(2));
   assign vec_fetch_o = (state_q == ST_MC) && (cnt_q == '0);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import ies_pkg::*;
#(
   parameter int WIN_LEN     = 5,
   parameter int ARB_CYC     = 5,
   parameter int NMI_SKIP    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MC_BASE     = 18,
   parameter int RF_EXTRA    = 2,
   parameter int SEG_EXTRA   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ext_req_i,
   input  logic nmi_req_i,
   input  logic wr_done_i,
   input  logic instr_done_i,
   input  logic wait_mode_i,
   input  logic stk_in_rf_i,
   input  logic push_seg_i,
   output logic abort_o,
   output logic ack_o,
   output logic push_o,
   output logic vec_fetch_o
);
   if (WIN_LEN < 2) begin : g_bad_win
      $error("WIN_LEN must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ARB_CYC < 1 || NMI_SKIP < 0 || NMI_SKIP >= ARB_CYC) begin : g_bad_arb
      $error("need ARB_CYC >= 1 and 0 <= NMI_SKIP < ARB_CYC");
   end
   if (MC_BASE < 3) begin : g_bad_mc
      $error("MC_BASE must be at least 3");
   end

   logic             tick;
   logic [N_SRC-1:0] req_vec;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] clr;

   assign req_vec[SRC_NMI] = nmi_req_i;
   assign req_vec[SRC_EXT] = ext_req_i;

   ies_window #(.WIN_LEN(WIN_LEN)) u_window (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      ies_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .req_i  (req_vec[s]),
         .clr_i  (clr[s]),
         .pend_o (pend[s])
      );
   end

   ies_fsm #(
      .ARB_CYC   (ARB_CYC),
      .NMI_SKIP  (NMI_SKIP),
      .MC_BASE   (MC_BASE),
      .RF_EXTRA  (RF_EXTRA),
      .SEG_EXTRA (SEG_EXTRA)
   ) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick),
      .pend_i       (pend),
      .wr_done_i    (wr_done_i),
      .instr_done_i (instr_done_i),
      .wait_mode_i  (wait_mode_i),
      .stk_in_rf_i  (stk_in_rf_i),
      .push_seg_i   (push_seg_i),
      .clr_o        (clr),
      .abort_o      (abort_o),
      .ack_o        (ack_o),
      .push_o       (push_o),
      .vec_fetch_o  (vec_fetch_o)
   );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic abort_o,
   input logic ack_o,
   input logic push_o,
   input logic vec_fetch_o
);
   // R7: acknowledge lasts a single cycle
   p_single_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |=> !ack_o);

   // R5: abort only ever accompanies the acknowledge
   p_abort_with_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> ack_o);

   // R8: acknowledge, push phase and vector fetch never overlap
   p_phases_apart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ack_o, push_o, vec_fetch_o}));

   // R8: vector fetch is a lone final strobe
   p_vec_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_fetch_o |=> (!vec_fetch_o && !push_o && !ack_o));

   // R9: push phase starts one or two cycles after the acknowledge
   p_push_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(push_o) |-> ($past(ack_o) || $past(ack_o, 2)));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .abort_o     (abort_o),
   .ack_o       (ack_o),
   .push_o      (push_o),
   .vec_fetch_o (vec_fetch_o)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_req = 1'b0, nmi_req = 1'b0;
   logic wr_done = 1'b0, instr_done = 1'b0, wait_mode = 1'b0;
   logic stk_rf = 1'b0, push_seg = 1'b0;
   logic abort_w, ack_w, push_w, vec_w;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   irq_entry_seq u_irq_entry_seq (
      .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext_req), .nmi_req_i(nmi_req),
      .wr_done_i(wr_done), .instr_done_i(instr_done), .wait_mode_i(wait_mode),
      .stk_in_rf_i(stk_rf), .push_seg_i(push_seg),
      .abort_o(abort_w), .ack_o(ack_w), .push_o(push_w), .vec_fetch_o(vec_w));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int next_grid(input int e);
      int k = e;
      while (k % 5 != 0) k++;
      return k;
   endfunction

   // R2 R4 R5 R6 R8 R9: one request, timing of every phase predicted
   task automatic run_case(input bit nmi, input bit wr, input bit rf,
                           input bit seg, input bit wm, input string tag);
      int a, k, arb, ack_x, vec_x, len;
      int ack_at = -1, vec_at = -1, pushes = 0, aborted = 0, acks = 0;
      @(negedge clk);
      wr_done = wr; wait_mode = wm; stk_rf = rf; push_seg = seg;
      @(negedge clk);
      if (nmi) nmi_req = 1'b1; else ext_req = 1'b1;
      a = cyc + 1;
      k = next_grid(a + 3);
      arb = nmi ? 1 : 5;
      ack_x = (wr && !wm) ? k + arb + 3 : k + arb;
      len = 18 + (rf ? 2 : 0) + (seg ? 2 : 0);
      vec_x = ack_x + (wm ? 1 : 0) + len;
      for (int i = 0; i < 200 && vec_at < 0; i++) begin
         @(negedge clk);
         if (ack_w) begin acks++; if (ack_at < 0) ack_at = cyc; if (abort_w) aborted = 1; end
         if (push_w) pushes++;
         if (vec_w) vec_at = cyc;
         instr_done = (wr && !wm && cyc == k + arb + 2);
      end
      instr_done = 1'b0;
      chk(ack_at == ack_x, {tag, " R2/R4 ack edge (R6 when wr)"}, ack_at, ack_x);
      chk(aborted == ((!wr && !wm) ? 1 : 0), {tag, " R5/R9 abort"}, aborted, (!wr && !wm) ? 1 : 0);
      chk(acks == 1, {tag, " R7 ack cycles"}, acks, 1);
      chk(pushes == len - 2, {tag, " R8 push cycles"}, pushes, len - 2);
      chk(vec_at == vec_x, {tag, " R8/R9 vector fetch edge"}, vec_at, vec_x);
      // R3: level held high, then falling edge, no further service
      acks = 0;
      repeat (12) begin @(negedge clk); if (ack_w) acks++; end
      nmi_req = 1'b0; ext_req = 1'b0;
      repeat (12) begin @(negedge clk); if (ack_w) acks++; end
      chk(acks == 0, {tag, " R3 no retrigger on level/fall"}, acks, 0);
      wait_mode = 1'b0; wr_done = 1'b0;
   endtask

   task automatic reset_state;
      int bad = 0;
      repeat (8) begin
         @(negedge clk);
         if (abort_w || ack_w || push_w || vec_w) bad++;
      end
      chk(bad == 0, "R1 outputs idle after reset", bad, 0);
   endtask

   // R4 R10: both lines rise together; non-maskable first, external held
   task automatic both_lines;
      int a, k, v, k2, ack1 = -1, ack2 = -1, vec1 = -1, abort2 = 0;
      @(negedge clk);
      wr_done = 1'b0; wait_mode = 1'b0; stk_rf = 1'b0; push_seg = 1'b0;
      @(negedge clk);
      nmi_req = 1'b1; ext_req = 1'b1;
      a = cyc + 1;
      k = next_grid(a + 3);
      v = k + 1 + 18;
      k2 = next_grid(v + 2);
      for (int i = 0; i < 200 && ack2 < 0; i++) begin
         @(negedge clk);
         if (ack_w) begin
            if (ack1 < 0) ack1 = cyc;
            else begin ack2 = cyc; abort2 = abort_w; end
         end
         if (vec_w && vec1 < 0) vec1 = cyc;
      end
      chk(ack1 == k + 1, "R4 non-maskable served first", ack1, k + 1);
      chk(vec1 == v, "R4 non-maskable vector fetch", vec1, v);
      chk(ack2 == k2 + 5, "R10 held external request served", ack2, k2 + 5);
      chk(abort2 == 1, "R5 held external aborts", abort2, 1);
      repeat (30) @(negedge clk);
      nmi_req = 1'b0; ext_req = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      int bad = 0;
      repeat (3) begin
         @(negedge clk);
         if (abort_w || ack_w || push_w || vec_w) bad++;
      end
      chk(bad == 0, "R1 outputs low in reset", bad, 0);
      rst_n = 1'b1;
      reset_state();
      run_case(0, 0, 0, 0, 0, "ext abort");
      run_case(0, 1, 0, 0, 0, "ext wait-for-done");
      run_case(0, 0, 1, 0, 0, "ext stack-rf");
      run_case(0, 0, 1, 1, 0, "ext rf+seg");
      run_case(0, 1, 0, 1, 0, "ext seg written");
      run_case(0, 0, 0, 0, 1, "ext wait-mode");
      run_case(0, 1, 1, 1, 1, "ext wait-mode full");
      run_case(1, 0, 0, 0, 0, "nmi abort");
      run_case(1, 1, 1, 0, 0, "nmi written rf");
      run_case(1, 0, 0, 1, 1, "nmi wait-mode seg");
      both_lines();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule